// File: doc/BRIEF.md
# Lexicographic k-subset generator

This block walks through every k-element subset of the integers 0 to n-1, presenting each one as a sorted tuple of 4-bit indices. A new subset appears on every clock cycle. The sequence is in lexicographic order, so the smallest tuple comes first and the largest comes last. n and k are runtime inputs that are captured when a start pulse is seen. n is at most 16, and both values must be even.

A downstream consumer accepts tuples with a ready input and can stall the sequence at any time. The final tuple is tagged with a last flag. Once that tuple has been accepted, the block raises done and keeps the final tuple on its output until the next start. If the values on the n and k inputs are illegal, the block produces no tuples and raises a one-cycle error pulse instead.

Top module: `comb_gen`

## Requirements
- R1: While rst_ni is low, valid_o, last_o, done_o and err_o are 0, and the block waits idle for start_i.
- R2: One cycle after start_i is sampled with legal inputs, valid_o is 1 and the tuple is the identity tuple, with slot j holding j for every j < k.
- R3: Each accepted tuple (valid_o and ready_i both high at a clock edge) is replaced by its lexicographic successor. A run therefore presents exactly C(n,k) distinct tuples, each of them once.
- R4: Within every presented tuple, the slot values strictly increase from slot 0 to slot k-1, and every value is below n.
- R5: While ready_i is held high, valid_o stays high on every cycle from the first tuple to the last, with no gaps.
- R6: While valid_o is high and ready_i is low, comb_o, mask_o and last_o hold their values and valid_o stays high.
- R7: last_o is high exactly on the tuple whose slot 0 equals n-k. After that tuple is accepted, valid_o falls and done_o rises on the next cycle. done_o and comb_o then hold until the next start_i clears done_o.
- R8: Bit j of mask_o is 1 exactly when j < k. Every slot whose mask bit is 0 reads zero.
- R9: The inputs are illegal when k is 0, k is greater than n, n is greater than 16, n is odd, or k is odd. With illegal inputs, a start_i raises err_o for exactly the following cycle, and valid_o stays 0.
- R10: Slot j of comb_o occupies bits [4j+3:4j].
- R11: When k equals n, the run has a single tuple, and last_o is already high on that first tuple.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Starts a run; honoured while the block is idle or done |
| n_i | input | 5 | Size of the set the values are drawn from |
| k_i | input | 5 | Number of elements in each tuple |
| ready_i | input | 1 | Consumer accepts the current tuple |
| valid_o | output | 1 | A tuple is presented |
| last_o | output | 1 | The presented tuple is the final one |
| done_o | output | 1 | The run has finished; held until the next start |
| err_o | output | 1 | One-cycle pulse after a start with illegal n or k |
| mask_o | output | 16 | Bit j set when slot j is active |
| comb_o | output | 64 | Sixteen 4-bit slots; slot j at bits [4j+3:4j] |

## Verification
The bench uses the default build: a limit of 16 on n and 4-bit slots. This means the widest legal case, n=16 with k=8 and 12,870 tuples, runs in full and fits the cycle budget. The k=n cases and the smallest case, n=2 with k=2, exercise the single-tuple boundary. Further runs apply a periodic ready stall in the middle of a run. The n=16 cases reach the top slot and the full 4-bit value range. Because the inputs are 5 bits wide, n=18 can be applied, which exercises the upper-limit error alongside the odd-value and k>n errors.

// File: rtl/comb_pkg.sv
package comb_pkg;
  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_RUN  = 2'd1,
    ST_DONE = 2'd2
  } gen_state_e;
endpackage

// File: rtl/comb_cfg_check.sv
module comb_cfg_check #(
  parameter int MAX_N = 16,
  parameter int CNT_W = $clog2(MAX_N + 1)
) (
  input  logic [CNT_W-1:0] n_i,
  input  logic [CNT_W-1:0] k_i,
  output logic             ok_o
);
  logic k_nz, k_fits, n_fits, both_even;

  assign k_nz      = (k_i != '0);
  assign k_fits    = (k_i <= n_i);
  assign n_fits    = (32'(n_i) <= MAX_N);
  assign both_even = !n_i[0] && !k_i[0];
  assign ok_o      = k_nz && k_fits && n_fits && both_even;
endmodule

// File: rtl/comb_succ.sv
module comb_succ #(
  parameter int MAX_N = 16,
  parameter int IDX_W = $clog2(MAX_N),
  parameter int CNT_W = $clog2(MAX_N + 1)
) (
  input  logic [MAX_N*IDX_W-1:0] cur_i,
  input  logic [CNT_W-1:0]       n_i,
  input  logic [CNT_W-1:0]       k_i,
  output logic [MAX_N*IDX_W-1:0] nxt_o,
  output logic                   is_last_o
);
  localparam int PW = CNT_W + 1;

  logic [PW-1:0]    n_w, k_w, span;
  logic [MAX_N-1:0] can_inc;
  logic [IDX_W-1:0] piv;
  logic             found;
  logic [PW-1:0]    base;

  assign n_w  = PW'(n_i);
  assign k_w  = PW'(k_i);
  assign span = n_w - k_w;

  // per-slot headroom: slot i may still grow while below n-k+i
  for (genvar i = 0; i < MAX_N; i++) begin : g_cmp
    assign can_inc[i] = (CNT_W'(i) < k_i) &&
                        (PW'(cur_i[i*IDX_W +: IDX_W]) < span + PW'(i));
  end

  // highest slot with headroom wins
  always_comb begin
    piv   = '0;
    found = 1'b0;
    for (int i = 0; i < MAX_N; i++) begin
      if (can_inc[i]) begin
        piv   = IDX_W'(i);
        found = 1'b1;
      end
    end
  end

  assign base = PW'(cur_i[piv*IDX_W +: IDX_W]) + PW'(1);

  for (genvar j = 0; j < MAX_N; j++) begin : g_fill
    logic [PW-1:0] refill;
    assign refill = base + PW'(j) - PW'(piv);
    always_comb begin
      if (CNT_W'(j) >= k_i)
        nxt_o[j*IDX_W +: IDX_W] = '0;
      else if (found && (IDX_W'(j) >= piv))
        nxt_o[j*IDX_W +: IDX_W] = IDX_W'(refill);
      else
        nxt_o[j*IDX_W +: IDX_W] = cur_i[j*IDX_W +: IDX_W];
    end
  end

  assign is_last_o = (PW'(cur_i[IDX_W-1:0]) == span);
endmodule

// File: rtl/comb_gen.sv
module comb_gen
  import comb_pkg::*;
#(
  parameter int MAX_N = 16,
  parameter int IDX_W = $clog2(MAX_N),
  parameter int CNT_W = $clog2(MAX_N + 1)
) (
  input  logic                   clk_i,
  input  logic                   rst_ni,
  input  logic                   start_i,
  input  logic [CNT_W-1:0]       n_i,
  input  logic [CNT_W-1:0]       k_i,
  input  logic                   ready_i,
  output logic                   valid_o,
  output logic                   last_o,
  output logic                   done_o,
  output logic                   err_o,
  output logic [MAX_N-1:0]       mask_o,
  output logic [MAX_N*IDX_W-1:0] comb_o
);
  gen_state_e             state_q;
  logic [CNT_W-1:0]       n_q, k_q;
  logic [MAX_N*IDX_W-1:0] comb_q, nxt, init;
  logic                   err_q, cfg_ok, is_last, can_start;

  comb_cfg_check #(.MAX_N(MAX_N), .CNT_W(CNT_W)) u_cfg (
    .n_i (n_i),
    .k_i (k_i),
    .ok_o(cfg_ok)
  );

  comb_succ #(.MAX_N(MAX_N), .IDX_W(IDX_W), .CNT_W(CNT_W)) u_succ (
    .cur_i    (comb_q),
    .n_i      (n_q),
    .k_i      (k_q),
    .nxt_o    (nxt),
    .is_last_o(is_last)
  );

  for (genvar j = 0; j < MAX_N; j++) begin : g_init
    assign init[j*IDX_W +: IDX_W] = (CNT_W'(j) < k_i) ? IDX_W'(j) : '0;
    assign mask_o[j]              = (CNT_W'(j) < k_q);
  end

  assign can_start = start_i && (state_q != ST_RUN);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_IDLE;
      n_q     <= '0;
      k_q     <= '0;
      comb_q  <= '0;
      err_q   <= 1'b0;
    end else begin
      err_q <= 1'b0;
      if (can_start) begin
        if (cfg_ok) begin
          n_q     <= n_i;
          k_q     <= k_i;
          comb_q  <= init;
          state_q <= ST_RUN;
        end else begin
          err_q   <= 1'b1;
          state_q <= ST_IDLE;
        end
      end else if (state_q == ST_RUN && ready_i) begin
        if (is_last) state_q <= ST_DONE;
        else         comb_q  <= nxt;
      end
    end
  end

  assign valid_o = (state_q == ST_RUN);
  assign done_o  = (state_q == ST_DONE);
  assign last_o  = valid_o && is_last;
  assign err_o   = err_q;
  assign comb_o  = comb_q;

  // R6
  stall_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_o && !ready_i) |=> (valid_o && $stable(comb_o) && $stable(mask_o) && $stable(last_o)));

  // R7
  last_to_done_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_o && ready_i && last_o) |=> (done_o && !valid_o));

  // R7
  done_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (done_o && !start_i) |=> (done_o && $stable(comb_o)));

  // R9
  err_cause_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    err_o |-> ($past(start_i) && !valid_o));

  // R5
  no_gap_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_o && ready_i && !last_o) |=> valid_o);

  for (genvar j = 0; j < MAX_N; j++) begin : g_slot_chk
    // R8
    idle_slot_zero_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (valid_o && !mask_o[j]) |-> (comb_o[j*IDX_W +: IDX_W] == '0));
    if (j + 1 < MAX_N) begin : g_ord
      // R4
      ascending_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (valid_o && mask_o[j+1]) |->
        (comb_o[j*IDX_W +: IDX_W] < comb_o[(j+1)*IDX_W +: IDX_W]));
    end
  end
endmodule

// File: tb/tb_comb_gen.sv
module tb_comb_gen;
  localparam int MAX_N = 16;
  localparam int IDX_W = 4;
  localparam int CNT_W = 5;
  localparam int NV    = 13;
  // {n[7:0], k[7:0], expected count[15:0]}; count 0 means illegal
  localparam logic [31:0] VEC [NV] = '{
    {8'd6,  8'd4,  16'd15},
    {8'd4,  8'd2,  16'd6},
    {8'd8,  8'd8,  16'd1},
    {8'd10, 8'd2,  16'd45},
    {8'd16, 8'd2,  16'd120},
    {8'd16, 8'd16, 16'd1},
    {8'd2,  8'd2,  16'd1},
    {8'd16, 8'd8,  16'd12870},
    {8'd5,  8'd2,  16'd0},
    {8'd6,  8'd3,  16'd0},
    {8'd4,  8'd0,  16'd0},
    {8'd4,  8'd6,  16'd0},
    {8'd18, 8'd2,  16'd0}
  };

  logic clk_i = 1'b0, rst_ni = 1'b0, start_i = 1'b0, ready_i = 1'b0;
  logic [CNT_W-1:0] n_i = '0, k_i = '0;
  logic valid_o, last_o, done_o, err_o;
  logic [MAX_N-1:0] mask_o;
  logic [MAX_N*IDX_W-1:0] comb_o;

  int checks = 0, fails = 0, cyc = 0;
  int model [MAX_N];

  always #5 clk_i = ~clk_i;

  comb_gen dut (.*);

  task automatic chk(input bit ok, input string req, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic logic [MAX_N*IDX_W-1:0] pack_model(input int k);
    logic [MAX_N*IDX_W-1:0] v = '0;
    for (int j = 0; j < k; j++) v[j*IDX_W +: IDX_W] = IDX_W'(model[j]);
    return v;
  endfunction

  task automatic advance(input int n, input int k);
    int p = -1;
    for (int i = 0; i < k; i++) if (model[i] < n - k + i) p = i;
    if (p >= 0) begin
      model[p]++;
      for (int j = p + 1; j < k; j++) model[j] = model[p] + (j - p);
    end
  endtask

  always @(posedge clk_i) begin
    cyc++;
    if (cyc > 150000) begin
      fails++;
      $display("FAIL watchdog actual=%0d expected<150000", cyc);
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  task automatic run_vec(input int n, input int k, input int cnt, input bit stall);
    int seen = 0, tick = 0;
    logic [MAX_N*IDX_W-1:0] last_tuple;
    @(negedge clk_i);
    n_i = CNT_W'(n); k_i = CNT_W'(k); start_i = 1'b1; ready_i = 1'b1;
    @(negedge clk_i);
    start_i = 1'b0;
    if (cnt == 0) begin
      chk(err_o && !valid_o, "R9 err pulse", {err_o, valid_o}, 2'b10);
      @(negedge clk_i);
      chk(!err_o && !valid_o, "R9 err single cycle", {err_o, valid_o}, 2'b00);
      return;
    end
    for (int j = 0; j < MAX_N; j++) model[j] = j < k ? j : 0;
    chk(valid_o && !done_o, "R2 valid after start, R7 done cleared", {valid_o, done_o}, 2'b10);
    chk(comb_o == pack_model(k), "R2 identity tuple, R10 packing", comb_o, pack_model(k));
    if (n == k) chk(last_o, "R11 single tuple last", last_o, 1);
    while (seen < cnt && tick < 40000) begin
      tick++;
      ready_i = stall ? ((tick % 3) != 2) : 1'b1;
      chk(valid_o, "R5 no gap / R6 hold valid", valid_o, 1);
      chk(comb_o == pack_model(k), "R3 lexicographic tuple", comb_o, pack_model(k));
      chk(mask_o == MAX_N'((32'd1 << k) - 1), "R8 mask", mask_o, (32'd1 << k) - 1);
      for (int j = 1; j < k; j++)
        if (comb_o[j*IDX_W +: IDX_W] <= comb_o[(j-1)*IDX_W +: IDX_W])
          chk(0, "R4 ascending", comb_o[j*IDX_W +: IDX_W], comb_o[(j-1)*IDX_W +: IDX_W] + 1);
      chk(last_o == (seen == cnt - 1), "R7 last flag", last_o, seen == cnt - 1);
      if (ready_i) begin
        seen++;
        if (seen < cnt) advance(n, k);
      end
      @(negedge clk_i);
    end
    last_tuple = pack_model(k);
    chk(seen == cnt, "R3 tuple count", seen, cnt);
    chk(done_o && !valid_o, "R7 done after last", {done_o, valid_o}, 2'b10);
    @(negedge clk_i);
    @(negedge clk_i);
    chk(done_o && comb_o == last_tuple, "R7 done holds tuple", comb_o, last_tuple);
  endtask

  initial begin
    #1;
    chk(!valid_o && !last_o && !done_o && !err_o, "R1 reset state",
        {valid_o, last_o, done_o, err_o}, 0);
    repeat (3) @(negedge clk_i);
    rst_ni = 1'b1;
    @(negedge clk_i);
    chk(!valid_o && !done_o && !err_o, "R1 idle after reset", {valid_o, done_o, err_o}, 0);
    for (int v = 0; v < NV; v++)
      run_vec(int'(VEC[v][31:24]), int'(VEC[v][23:16]), int'(VEC[v][15:0]), v % 2 == 1);
    // ready low: tuple must not move (R6)
    @(negedge clk_i);
    n_i = 5'd6; k_i = 5'd2; start_i = 1'b1; ready_i = 1'b0;
    @(negedge clk_i);
    start_i = 1'b0;
    repeat (4) @(negedge clk_i);
    chk(valid_o && comb_o == 64'h10, "R6 stalled tuple", comb_o, 64'h10);
    ready_i = 1'b1;
    @(negedge clk_i);
    chk(comb_o == 64'h20, "R3 resume successor", comb_o, 64'h20);
    // mid-run reset (R1)
    rst_ni = 1'b0;
    #1;
    chk(!valid_o && !last_o && !done_o && !err_o, "R1 async reset mid-run",
        {valid_o, last_o, done_o, err_o}, 0);
    @(negedge clk_i);
    rst_ni = 1'b1;
    @(negedge clk_i);
    chk(!valid_o && !done_o, "R1 stays idle", {valid_o, done_o}, 0);
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule